// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the results of instructions that have been issued but not yet retired, and lets them leave strictly in program order. When an instruction is dispatched, the block reserves the slot at its tail and records the instruction's kind and destination. The slot number goes back to the dispatcher, which uses it as the result tag. Execution units later broadcast a value along with that tag. The matching slot stores the value and marks itself complete.

Once per cycle the oldest slot is examined. If it is complete, it retires:

- a register-kind slot drives the register-file write port;
- a store-kind slot drives the store port;
- a correctly predicted branch simply leaves.

A branch that was flagged as mispredicted raises a flush when it retires. That flush discards every younger slot. Newly issued instructions can also read a slot's value by tag. A broadcast that arrives in the same cycle as the read is forwarded to the reader.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0), `alloc_ready`=1, `alloc_tag`=0, and `rf_we`, `st_we` and `flush` are all 0.
- R2: Each accepted allocation returns the current tail slot as `alloc_tag`. Tags increase by one modulo DEPTH (8). With DEPTH slots occupied, `full`=1 and `alloc_ready`=0, and any request made then is dropped.
- R3: A broadcast (`wb_valid`) stores `wb_value` and the mispredict flag in slot `wb_tag` and marks the slot complete. A broadcast to a slot that is not occupied has no effect.
- R4: At most one slot retires per cycle, and only the oldest. It retires only when complete, so complete younger slots wait behind an incomplete older one.
- R5: A retiring slot of kind 0 (register) asserts `rf_we` with `rf_addr` = its destination and `rf_data` = its value.
- R6: A retiring slot of kind 1 (store) asserts `st_we` with `st_addr` = its destination and `st_data` = its value.
- R7: A slot of kind 2 (branch) that completes without the mispredict flag retires with no write and no flush.
- R8: A kind-2 slot that completes with the mispredict flag asserts `flush` for its retiring cycle, with no write. Every younger slot is discarded and never retires. The buffer is empty on the next cycle, and the next tag is the branch's slot plus one. No allocation is accepted in the flush cycle.
- R9: `rd_ready` is 1 for an occupied slot that is complete, and `rd_value` then carries its value. It is also 1 when a broadcast to `rd_tag` arrives in the same cycle, and `rd_value` then carries `wb_value`. It is 0 for an occupied slot that is not yet complete.
- R10: An allocation and a retirement can happen in the same cycle. The occupancy is then unchanged and both take effect.
- R11: `empty` is 1 exactly when no slot is occupied. `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch request |
| alloc_kind | input | 2 | Instruction kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register or store address |
| alloc_ready | output | 1 | Request will be accepted this cycle |
| alloc_tag | output | clog2(DEPTH) | Slot given to the request |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | clog2(DEPTH) | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Branch was mispredicted |
| rd_tag | input | clog2(DEPTH) | Slot read as an operand |
| rd_ready | output | 1 | Operand value is available |
| rd_value | output | DATA_W | Operand value |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | REG_W | Register written |
| rf_data | output | DATA_W | Data written |
| st_we | output | 1 | Store strobe |
| st_addr | output | REG_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Mispredicted branch retired, younger slots discarded |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The assertions check four things on every cycle:

- the occupancy never exceeds the depth;
- a flush leaves the pointers together with nothing occupied;
- a simultaneous allocation and retirement keeps the occupancy;
- a broadcast to an occupied, incomplete slot marks it complete.

They also check that the write, store and flush strobes never overlap, and that an accepted allocation clears `empty`.

Only the bench scenarios can show the rest. That covers retirement order when results arrive out of order, and the exact destination and data on each port. It also covers tag wraparound over many rounds, forwarding to a same-cycle operand read, and younger slots never surfacing after a flush. Finally, it covers a dropped request when full, and a broadcast to a vacant slot that is ignored.

// File: rtl/retire_pkg.sv
package retire_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;
endpackage

// File: rtl/rq_ptrs.sv
module rq_ptrs #(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_req,
    input  logic                     commit_fire,
    input  logic                     flush_fire,
    output logic [$clog2(DEPTH)-1:0] head,
    output logic [$clog2(DEPTH)-1:0] tail,
    output logic                     full,
    output logic                     empty,
    output logic                     alloc_fire
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t state_d, state_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full       = (state_q.count == CNT_W'(DEPTH));
        empty      = (state_q.count == '0);
        alloc_fire = alloc_req && !full && !flush_fire;
        head       = state_q.head;
        tail       = state_q.tail;

        state_d = state_q;
        if (flush_fire) begin
            state_d.head  = step(state_q.head);
            state_d.tail  = step(state_q.head);
            state_d.count = '0;
        end else begin
            if (commit_fire) state_d.head = step(state_q.head);
            if (alloc_fire)  state_d.tail = step(state_q.tail);
            if (alloc_fire && !commit_fire)
                state_d.count = state_q.count + 1'b1;
            else if (!alloc_fire && commit_fire)
                state_d.count = state_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.count <= CNT_W'(DEPTH));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> (state_q.count == '0 && state_q.tail == state_q.head));

    assert_simul_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && commit_fire && !flush_fire) |=> state_q.count == $past(state_q.count));
endmodule

// File: rtl/rq_store.sv
module rq_store
    import retire_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int REG_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_fire,
    input  logic [$clog2(DEPTH)-1:0] alloc_idx,
    input  kind_e                    alloc_kind,
    input  logic [REG_W-1:0]         alloc_dest,
    input  logic                     wb_valid,
    input  logic [$clog2(DEPTH)-1:0] wb_tag,
    input  logic [DATA_W-1:0]        wb_value,
    input  logic                     wb_mispredict,
    input  logic                     commit_fire,
    input  logic                     flush_fire,
    input  logic [$clog2(DEPTH)-1:0] head,
    input  logic [$clog2(DEPTH)-1:0] rd_tag,
    output logic                     head_ready,
    output kind_e                    head_kind,
    output logic [REG_W-1:0]         head_dest,
    output logic [DATA_W-1:0]        head_value,
    output logic                     head_mis,
    output logic                     rd_ready,
    output logic [DATA_W-1:0]        rd_value
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0]             done;
        logic [DEPTH-1:0]             mis;
        logic [DEPTH-1:0][1:0]        kind;
        logic [DEPTH-1:0][REG_W-1:0]  dest;
        logic [DEPTH-1:0][DATA_W-1:0] value;
    } slot_state_t;

    slot_state_t slot_d, slot_q;
    logic        wb_hit;
    logic        fwd_hit;

    always_comb begin
        wb_hit  = wb_valid && slot_q.valid[wb_tag] && !slot_q.done[wb_tag];
        fwd_hit = wb_valid && (wb_tag == rd_tag) && slot_q.valid[rd_tag];

        head_ready = slot_q.valid[head] && slot_q.done[head];
        head_kind  = kind_e'(slot_q.kind[head]);
        head_dest  = slot_q.dest[head];
        head_value = slot_q.value[head];
        head_mis   = slot_q.mis[head];

        rd_ready = slot_q.valid[rd_tag] && (slot_q.done[rd_tag] || fwd_hit);
        rd_value = fwd_hit ? wb_value : slot_q.value[rd_tag];

        slot_d = slot_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wb_hit && (wb_tag == IDX_W'(i))) begin
                slot_d.done[i]  = 1'b1;
                slot_d.value[i] = wb_value;
                slot_d.mis[i]   = wb_mispredict;
            end
            if (commit_fire && (head == IDX_W'(i))) slot_d.valid[i] = 1'b0;
            if (flush_fire) slot_d.valid[i] = 1'b0;
            if (alloc_fire && (alloc_idx == IDX_W'(i))) begin
                slot_d.valid[i] = 1'b1;
                slot_d.done[i]  = 1'b0;
                slot_d.mis[i]   = 1'b0;
                slot_d.kind[i]  = alloc_kind;
                slot_d.dest[i]  = alloc_dest;
                slot_d.value[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assert_capture_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_hit |=> slot_q.done[$past(wb_tag)]);
endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
    import retire_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int REG_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [1:0]               alloc_kind,
    input  logic [REG_W-1:0]         alloc_dest,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_tag,
    input  logic                     wb_valid,
    input  logic [$clog2(DEPTH)-1:0] wb_tag,
    input  logic [DATA_W-1:0]        wb_value,
    input  logic                     wb_mispredict,
    input  logic [$clog2(DEPTH)-1:0] rd_tag,
    output logic                     rd_ready,
    output logic [DATA_W-1:0]        rd_value,
    output logic                     rf_we,
    output logic [REG_W-1:0]         rf_addr,
    output logic [DATA_W-1:0]        rf_data,
    output logic                     st_we,
    output logic [REG_W-1:0]         st_addr,
    output logic [DATA_W-1:0]        st_data,
    output logic                     flush,
    output logic                     full,
    output logic                     empty
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]  head, tail;
    logic              alloc_fire, commit_fire, flush_fire;
    logic              head_ready, head_mis;
    kind_e             head_kind;
    logic [REG_W-1:0]  head_dest;
    logic [DATA_W-1:0] head_value;

    always_comb begin
        commit_fire = head_ready;
        flush_fire  = head_ready && (head_kind == KIND_BRANCH) && head_mis;
        alloc_ready = !full && !flush_fire;
        alloc_tag   = tail;
        rf_we       = commit_fire && (head_kind == KIND_REG);
        rf_addr     = head_dest;
        rf_data     = head_value;
        st_we       = commit_fire && (head_kind == KIND_STORE);
        st_addr     = head_dest;
        st_data     = head_value;
        flush       = flush_fire;
    end

    rq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_valid),
        .commit_fire (commit_fire),
        .flush_fire  (flush_fire),
        .head        (head),
        .tail        (tail),
        .full        (full),
        .empty       (empty),
        .alloc_fire  (alloc_fire)
    );

    rq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_fire    (alloc_fire),
        .alloc_idx     (tail),
        .alloc_kind    (kind_e'(alloc_kind)),
        .alloc_dest    (alloc_dest),
        .wb_valid      (wb_valid),
        .wb_tag        (wb_tag),
        .wb_value      (wb_value),
        .wb_mispredict (wb_mispredict),
        .commit_fire   (commit_fire),
        .flush_fire    (flush_fire),
        .head          (head),
        .rd_tag        (rd_tag),
        .head_ready    (head_ready),
        .head_kind     (head_kind),
        .head_dest     (head_dest),
        .head_value    (head_value),
        .head_mis      (head_mis),
        .rd_ready      (rd_ready),
        .rd_value      (rd_value)
    );

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_we, flush}));

    assert_alloc_not_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> !empty);

    assert_full_vs_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/inorder_retire_buf_test.sv
`timescale 1ns/1ps
module inorder_retire_buf_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_kind = '0;
    logic [4:0]  alloc_dest = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [15:0] wb_value = '0;
    logic        wb_mispredict = 1'b0;
    logic [2:0]  rd_tag = '0;
    logic        rd_ready;
    logic [15:0] rd_value;
    logic        rf_we, st_we, flush, full, empty;
    logic [4:0]  rf_addr, st_addr;
    logic [15:0] rf_data, st_data;

    int n_chk = 0;
    int n_fail = 0;
    int exp_tail = 0;

    always #2.5 clk = ~clk;

    inorder_retire_buf uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispredict(wb_mispredict),
        .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_value(rd_value),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
        .flush(flush), .full(full), .empty(empty)
    );

    function automatic int val(int i);
        return 256 + i * 37;
    endfunction

    task automatic chk_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(int kind, int dest);
        alloc_valid = 1'b1;
        alloc_kind  = 2'(kind);
        alloc_dest  = 5'(dest);
        #0.1;
        chk_eq("R2 tag", int'(alloc_tag), exp_tail);
        chk_eq("R2 ready", int'(alloc_ready), 1);
        tick();
        alloc_valid = 1'b0;
        exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic do_wb(int tag, int value, bit mis);
        wb_valid      = 1'b1;
        wb_tag        = 3'(tag);
        wb_value      = 16'(value);
        wb_mispredict = mis;
        tick();
        wb_valid      = 1'b0;
        wb_mispredict = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #0.1;
        // R1 reset state
        chk_eq("R1 empty", int'(empty), 1);
        chk_eq("R1 full", int'(full), 0);
        chk_eq("R1 ready", int'(alloc_ready), 1);
        chk_eq("R1 tag", int'(alloc_tag), 0);
        chk_eq("R1 strobes", int'({rf_we, st_we, flush}), 0);

        // R2 fill all slots, then a dropped request
        for (int i = 0; i < DEPTH; i++) do_alloc(0, i + 1);
        chk_eq("R2 full", int'(full), 1);
        chk_eq("R2 not ready", int'(alloc_ready), 0);
        alloc_valid = 1'b1; alloc_dest = 5'd31;
        tick();
        alloc_valid = 1'b0;

        // R4 younger results first: nothing retires
        for (int i = 1; i < DEPTH; i++) begin
            do_wb(i, val(i), 1'b0);
            chk_eq("R4 waits on head", int'(rf_we), 0);
        end
        // R9 operand reads
        rd_tag = 3'd5; #0.1;
        chk_eq("R9 ready done", int'(rd_ready), 1);
        chk_eq("R9 value", int'(rd_value), val(5));
        rd_tag = 3'd0; #0.1;
        chk_eq("R9 not ready", int'(rd_ready), 0);
        wb_valid = 1'b1; wb_tag = 3'd0; wb_value = 16'(val(0)); #0.1;
        chk_eq("R9 forward ready", int'(rd_ready), 1);
        chk_eq("R9 forward value", int'(rd_value), val(0));
        tick();
        wb_valid = 1'b0;
        // R4/R5 in-order retirement, one per cycle
        for (int i = 0; i < DEPTH; i++) begin
            chk_eq("R5 rf_we", int'(rf_we), 1);
            chk_eq("R4 rf_addr order", int'(rf_addr), i + 1);
            chk_eq("R5 rf_data", int'(rf_data), val(i));
            tick();
        end
        chk_eq("R2 dropped request / R11 empty", int'(empty), 1);
        chk_eq("R4 no extra commit", int'(rf_we), 0);

        // R6 R7 rounds with wraparound
        for (int r = 0; r < 5; r++) begin
            int base;
            base = exp_tail;
            do_alloc(0, 10 + r);
            do_alloc(1, 20 + r);
            do_alloc(2, 0);
            do_wb((base + 2) % DEPTH, 0, 1'b0);
            do_wb((base + 1) % DEPTH, 500 + r, 1'b0);
            chk_eq("R4 head incomplete", int'(rf_we | st_we), 0);
            do_wb(base, 300 + r, 1'b0);
            chk_eq("R5 round addr", int'(rf_we ? rf_addr : 5'd0), 10 + r);
            chk_eq("R5 round data", int'(rf_data), 300 + r);
            tick();
            chk_eq("R6 st_we", int'(st_we), 1);
            chk_eq("R6 st_addr", int'(st_addr), 20 + r);
            chk_eq("R6 st_data", int'(st_data), 500 + r);
            chk_eq("R6 no rf_we", int'(rf_we), 0);
            tick();
            chk_eq("R7 branch quiet", int'({rf_we, st_we, flush}), 0);
            chk_eq("R7 not empty", int'(empty), 0);
            tick();
            chk_eq("R7 retired", int'(empty), 1);
        end

        // R10 allocation and retirement together
        begin
            int base;
            base = exp_tail;
            do_alloc(0, 3);
            do_wb(base, 77, 1'b0);
            chk_eq("R10 commit pending", int'(rf_we), 1);
            alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd7; #0.1;
            chk_eq("R10 tag", int'(alloc_tag), exp_tail);
            chk_eq("R10 ready", int'(alloc_ready), 1);
            tick();
            alloc_valid = 1'b0;
            exp_tail = (exp_tail + 1) % DEPTH;
            chk_eq("R10 not empty", int'(empty), 0);
            chk_eq("R10 new not done", int'(rf_we), 0);
            do_wb((base + 1) % DEPTH, 88, 1'b0);
            chk_eq("R10 addr", int'(rf_addr), 7);
            chk_eq("R10 data", int'(rf_data), 88);
            tick();
            chk_eq("R10 empty", int'(empty), 1);
        end

        // R8 mispredicted branch
        begin
            int t0, t1, t2, t3;
            t0 = exp_tail; t1 = (t0 + 1) % DEPTH; t2 = (t0 + 2) % DEPTH; t3 = (t0 + 3) % DEPTH;
            do_alloc(0, 4);
            do_alloc(2, 0);
            do_alloc(0, 5);
            do_alloc(1, 6);
            do_wb(t2, 11, 1'b0);
            do_wb(t3, 12, 1'b0);
            do_wb(t1, 0, 1'b1);
            do_wb(t0, 13, 1'b0);
            chk_eq("R8 older commits", int'(rf_addr), 4);
            chk_eq("R8 older data", int'(rf_data), 13);
            tick();
            chk_eq("R8 flush", int'(flush), 1);
            chk_eq("R8 no write", int'(rf_we | st_we), 0);
            chk_eq("R8 no alloc in flush", int'(alloc_ready), 0);
            tick();
            chk_eq("R8 empty", int'(empty), 1);
            chk_eq("R8 flush pulse", int'(flush), 0);
            chk_eq("R8 next tag", int'(alloc_tag), t1 + 1 == DEPTH ? 0 : t1 + 1);
            exp_tail = (t1 + 1) % DEPTH;
            for (int k = 0; k < 3; k++) begin
                chk_eq("R8 younger discarded", int'(rf_we | st_we), 0);
                tick();
            end

            // R3 broadcast to a vacant slot is ignored
            do_wb(t2, 99, 1'b0);
            do_alloc(0, 9);
            rd_tag = 3'(t2); #0.1;
            chk_eq("R3 vacant wb ignored", int'(rd_ready), 0);
            chk_eq("R3 no commit", int'(rf_we), 0);
            do_wb(t2, 55, 1'b0);
            chk_eq("R3 capture", int'(rf_data), 55);
            chk_eq("R3 addr", int'(rf_addr), 9);
            tick();
            chk_eq("R11 empty end", int'(empty), 1);
        end

        summary();
    end
endmodule